// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block lets an SMBus host read and write a small bank of configuration bytes inside the chip. SCL and SDA are oversampled by a fast system clock through two-stage synchronizers. The block answers only at its own 7-bit address. It drives SDA through an open-drain enable, which pulls the line low when set. The command byte chooses between a single-byte access at an explicit offset and a block access. A block access always begins at the first implemented index (4) and walks upward one byte at a time.

The implemented bytes are indices 4 to 14. Index 5 reflects a read-only status input, such as latched strap pins. Index 8 is a fixed read-only signature. All other implemented indices are writable storage, and their current values are presented on a packed output bus for the rest of the chip. The block does not stretch the clock. It has no packet error code and no alert line.

Top module: `smbr_slave`

## Requirements
- R1: A START or repeated START always restarts the address phase, even in the middle of a transfer, and the access that follows uses the command given after it. A STOP returns the block to idle with SDA released.
- R2: The address byte 0xD2 (7-bit address 69h, write) and 0xD3 (read) are acknowledged. Any other address gets no acknowledge, and the rest of that transfer has no effect on any register.
- R3: A command byte with bit 7 = 1 selects a single-byte access at offset bits 6:0. A byte write (address+W, command, one data byte) stores that byte at that offset and acknowledges every byte.
- R4: A byte read (address+W, command, repeated START, address+R) returns the byte at the commanded offset, MSB first. The master's NACK ends the read.
- R5: A command byte with bit 7 = 0 selects a block access. In a block write, the first byte after the command is a byte count, which is acknowledged and discarded. The data bytes that follow are stored at indices 4, 5, 6 and upward in order, and the master may stop after any whole byte.
- R6: A block read first returns a count byte equal to the number of implemented bytes (11). It then returns the bytes at indices 4, 5, 6 and upward, one per master ACK, until the master NACKs.
- R7: After reset the bytes read: index 4 = 00h, 6 = 0Bh, 7 = FFh, 9 = B0h, 10 = FFh, 11 = 00h, 12 = 80h, 13 = 00h, 14 = 00h.
- R8: Index 5 reads {2'b00, strap_i[5:0]} and index 8 reads 80h. A data byte aimed at index 5, index 8 or any offset outside 4..14 is acknowledged and discarded. Offsets outside 4..14 read 00h.
- R9: The block changes its SDA pull-down only while SCL is low, and only ever pulls SDA low.
- R10: cfg_o carries the read value of index 4+i in bits [8i+7:8i] for i = 0..10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| strap_i | input | 6 | Read-only status bits presented at index 5 |
| cfg_o | output | 88 | Read values of indices 4..14, index 4 in the low byte |

## Verification
The bench builds the block with its default parameters: address 69h, 11 implemented bytes starting at index 4, status at index 5 and signature at index 8. With that small map, every one of the 128 seven-bit addresses can be tried. Byte writes and reads also sweep offsets 0 to 20 and 127, which covers every implemented index, both read-only ones and the unimplemented space on either side. Block transfers, a repeated START in the middle of a write, and a misaddressed transfer complete the set. Expected values come from a byte model in the bench that applies the writability rule directly.

// File: rtl/smbr_pkg.sv
// Shared types and the reset map for the SMBus register slave.
// Assumes offsets fit the 7-bit offset field of the command byte.
package smbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXACK,
        ST_TX,
        ST_TXACK
    } smbr_state_t;

    typedef enum logic [1:0] {
        K_ADDR,
        K_CMD,
        K_CNT,
        K_DATA
    } smbr_kind_t;

    // Power-up value of a writable byte at a given index.
    function automatic logic [7:0] reset_value(int idx);
        case (idx)
            6:       return 8'h0B;
            7:       return 8'hFF;
            9:       return 8'hB0;
            10:      return 8'hFF;
            12:      return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smbr_sync.sv
// Multi-bit two-flop synchronizer for bus pins. Resets to 1 (idle bus level).
// Assumes each bit is independent, which holds for SCL and SDA.
module smbr_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta;

    // Two-stage capture of asynchronous pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '1;
            q_o  <= '1;
        end else begin
            meta <= d_i;
            q_o  <= meta;
        end
    end
endmodule

// File: rtl/smbr_bus_cond.sv
// Detects SCL edges and START/STOP conditions from synchronized pin levels.
// START is SDA falling while SCL stays high. STOP is SDA rising while SCL stays high.
module smbr_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    // Delayed copies used for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smbr_regbank.sv
// Configuration byte bank covering indices BASE_IDX .. BASE_IDX+NUM_REGS-1.
// One index shows the status input and one shows a fixed signature; all others are storage.
// Any index outside the range reads zero. Writes to read-only slots are ignored.
module smbr_regbank #(
    parameter int         BASE_IDX  = 4,
    parameter int         NUM_REGS  = 11,
    parameter int         STRAP_IDX = 5,
    parameter int         SIG_IDX   = 8,
    parameter logic [7:0] SIGNATURE = 8'h80,
    parameter int         STRAP_W   = 6,
    parameter int         IDX_W     = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IDX_W-1:0]      widx,
    input  logic [7:0]            wdata,
    input  logic [IDX_W-1:0]      ridx,
    output logic [7:0]            rdata,
    input  logic [STRAP_W-1:0]    strap_i,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    import smbr_pkg::*;

    logic [7:0] view [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        localparam int IDX = BASE_IDX + g;
        if (IDX == STRAP_IDX) begin : g_strap
            assign view[g] = {{(8-STRAP_W){1'b0}}, strap_i};
        end else if (IDX == SIG_IDX) begin : g_sig
            assign view[g] = SIGNATURE;
        end else begin : g_store
            logic [7:0] q;
            // Writable byte with its own power-up value.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= reset_value(IDX);
                end else if (we && int'(widx) == IDX) begin
                    q <= wdata;
                end
            end
            assign view[g] = q;
        end
        assign cfg_o[g*8 +: 8] = view[g];
    end

    // Read multiplexer; unmatched indices give zero.
    always_comb begin
        rdata = 8'h00;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (int'(ridx) == BASE_IDX + k) rdata = view[k];
        end
    end
endmodule

// File: rtl/smbr_slave.sv
// SMBus slave giving byte and block access to the configuration bank.
// Assumes clk is at least several times faster than SCL, so that each SCL phase
// lasts longer than the synchronizer delay. Never stretches the clock.
module smbr_slave #(
    parameter logic [6:0] ADDR7     = 7'h69,
    parameter int         BASE_IDX  = 4,
    parameter int         NUM_REGS  = 11,
    parameter int         STRAP_IDX = 5,
    parameter int         SIG_IDX   = 8,
    parameter logic [7:0] SIGNATURE = 8'h80,
    parameter int         STRAP_W   = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic [STRAP_W-1:0]    strap_i,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    import smbr_pkg::*;

    localparam int         IDX_W    = 7;
    localparam int         LAST_IDX = BASE_IDX + NUM_REGS - 1;
    localparam logic [6:0] BASE7    = 7'(BASE_IDX);
    localparam logic [7:0] COUNT8   = 8'(NUM_REGS);

    logic            scl_s, sda_s;
    logic            scl_rise, scl_fall, start_det, stop_det;
    smbr_state_t     state;
    smbr_kind_t      kind;
    logic [3:0]      bitcnt;
    logic [7:0]      shreg, txsh, tx_load, rdata;
    logic            rw, blk, first, mack, oe_q;
    logic [IDX_W-1:0] ptr, rd_idx;
    logic            writable, byte_end, we;

    smbr_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
    );

    smbr_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smbr_regbank #(
        .BASE_IDX(BASE_IDX), .NUM_REGS(NUM_REGS), .STRAP_IDX(STRAP_IDX),
        .SIG_IDX(SIG_IDX), .SIGNATURE(SIGNATURE), .STRAP_W(STRAP_W), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .we(we), .widx(ptr), .wdata(shreg),
        .ridx(rd_idx), .rdata(rdata), .strap_i(strap_i), .cfg_o(cfg_o)
    );

    // Byte-end, write-qualify and read-source selection.
    always_comb begin
        byte_end = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
        writable = (int'(ptr) >= BASE_IDX) && (int'(ptr) <= LAST_IDX) &&
                   (int'(ptr) != STRAP_IDX) && (int'(ptr) != SIG_IDX);
        we       = byte_end && (kind == K_DATA) && writable;
        rd_idx   = (state == ST_TXACK && !first) ? ptr + 7'd1 : ptr;
        tx_load  = (state == ST_RXACK && first) ? COUNT8 : rdata;
    end

    // Protocol sequencer: byte reception, acknowledge and byte transmission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind   <= K_ADDR;
            bitcnt <= '0;
            shreg  <= '0;
            txsh   <= '0;
            rw     <= 1'b0;
            blk    <= 1'b0;
            first  <= 1'b0;
            mack   <= 1'b0;
            ptr    <= '0;
            oe_q   <= 1'b0;
        end else if (stop_det) begin
            state <= ST_IDLE;
            oe_q  <= 1'b0;
        end else if (start_det) begin
            state  <= ST_RX;
            kind   <= K_ADDR;
            bitcnt <= '0;
            oe_q   <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise && bitcnt != 4'd8) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_end) begin
                        oe_q  <= 1'b1;
                        state <= ST_RXACK;
                        case (kind)
                            K_ADDR: begin
                                if (shreg[7:1] != ADDR7) begin
                                    oe_q  <= 1'b0;
                                    state <= ST_IDLE;
                                end else begin
                                    rw <= shreg[0];
                                end
                            end
                            K_CMD: begin
                                blk   <= ~shreg[7];
                                first <= ~shreg[7];
                                ptr   <= shreg[7] ? shreg[6:0] : BASE7;
                            end
                            K_DATA:  ptr <= ptr + 7'd1;
                            default: ;
                        endcase
                    end
                end
                ST_RXACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (kind == K_ADDR && rw) begin
                            state <= ST_TX;
                            txsh  <= tx_load;
                            oe_q  <= ~tx_load[7];
                        end else begin
                            state <= ST_RX;
                            oe_q  <= 1'b0;
                            case (kind)
                                K_ADDR:  kind <= K_CMD;
                                K_CMD:   kind <= blk ? K_CNT : K_DATA;
                                default: kind <= K_DATA;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            oe_q  <= 1'b0;
                            state <= ST_TXACK;
                        end else begin
                            bitcnt <= bitcnt + 4'd1;
                            txsh   <= {txsh[6:0], 1'b0};
                            oe_q   <= ~txsh[6];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            state  <= ST_TX;
                            bitcnt <= '0;
                            txsh   <= tx_load;
                            oe_q   <= ~tx_load[7];
                            if (first) first <= 1'b0;
                            else       ptr   <= ptr + 7'd1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe = oe_q;
endmodule

// File: rtl/smbr_slave_chk.sv
// Protocol checker for smbr_slave, attached through bind.
module smbr_slave_chk #(
    parameter int STRAP_IDX = 5,
    parameter int SIG_IDX   = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  start_det,
    input logic                  stop_det,
    input logic                  sda_oe,
    input smbr_pkg::smbr_state_t state,
    input logic [3:0]            bitcnt,
    input logic                  we,
    input logic [6:0]            ptr
);
    import smbr_pkg::*;

    assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det && !stop_det |=> state == ST_RX && bitcnt == 4'd0);

    assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state == ST_IDLE && !sda_oe);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_oe);

    assert_ro_not_written_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> int'(ptr) != STRAP_IDX && int'(ptr) != SIG_IDX);

    assert_sda_moves_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);
endmodule

bind smbr_slave smbr_slave_chk #(.STRAP_IDX(STRAP_IDX), .SIG_IDX(SIG_IDX)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .sda_oe(sda_oe), .state(state), .bitcnt(bitcnt),
    .we(we), .ptr(ptr)
);

// File: tb/smbr_slave_bench.sv
module smbr_slave_bench;
    localparam int Q = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [5:0]  strap = 6'h2B;
    logic [87:0] cfg;
    wire         sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int glitches = 0;
    bit done = 0;
    logic [7:0] expv [128];

    always #2 clk = ~clk;

    smbr_slave u_smbr_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(strap), .cfg_o(cfg)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    // One clock pulse; samples the line mid-high and records pull-down changes while SCL is high.
    task automatic bit_io(input logic b, output logic seen);
        logic snap;
        sda_m = b; wq(); scl_m = 1'b1; wq();
        snap = sda_oe; seen = sda_line; wq();
        if (sda_oe !== snap) glitches++;
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(d[i], s);
        bit_io(1'b1, s);
        ack = (s == 1'b0);
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit mack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            d[i] = s;
        end
        bit_io(~mack, s);
    endtask

    task automatic byte_write(input logic [6:0] off, input logic [7:0] d, output bit ok);
        bit a1, a2, a3;
        bus_start(); send_byte(8'hD2, a1); send_byte({1'b1, off}, a2); send_byte(d, a3); bus_stop();
        ok = a1 && a2 && a3;
    endtask

    task automatic byte_read(input logic [6:0] off, output logic [7:0] d, output bit ok);
        bit a1, a2, a3;
        bus_start(); send_byte(8'hD2, a1); send_byte({1'b1, off}, a2);
        bus_start(); send_byte(8'hD3, a3); recv_byte(d, 1'b0); bus_stop();
        ok = a1 && a2 && a3;
    endtask

    function automatic bit is_writable(int idx);
        return idx >= 4 && idx <= 14 && idx != 5 && idx != 8;
    endfunction

    function automatic logic [87:0] exp_cfg();
        logic [87:0] v;
        for (int i = 0; i < 11; i++) v[i*8 +: 8] = expv[4+i];
        return v;
    endfunction

    task automatic sweep_reads(input string req);
        logic [7:0] d;
        bit ok;
        for (int o = 0; o <= 21; o++) begin
            int off = (o == 21) ? 127 : o;
            byte_read(7'(off), d, ok);
            chk(ok, {req, " read ack (R4)"}, 128'(ok), 128'(1));
            chk(d === expv[off], {req, " byte read value (R4/R8)"}, 128'(d), 128'(expv[off]));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        bit ok, a1, a2, a3, a4;
        for (int i = 0; i < 128; i++) expv[i] = 8'h00;
        expv[4] = 8'h00; expv[5] = 8'h2B; expv[6] = 8'h0B; expv[7] = 8'hFF; expv[8] = 8'h80;
        expv[9] = 8'hB0; expv[10] = 8'hFF; expv[12] = 8'h80;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Reset state: R7 and R10 via the packed output, R1 line released.
        chk(sda_oe === 1'b0, "R1 idle release", 128'(sda_oe), 128'(0));
        chk(cfg === exp_cfg(), "R7/R10 reset cfg_o", 128'(cfg), 128'(exp_cfg()));

        // R2: every 7-bit address; only 69h acknowledged.
        for (int a = 0; a < 128; a++) begin
            bus_start(); send_byte({7'(a), 1'b0}, a1); bus_stop();
            chk(a1 == (a == 'h69), "R2 address ack", 128'(a1), 128'(a == 'h69));
        end

        // R7/R8: defaults across implemented and unimplemented offsets.
        sweep_reads("R7");

        // R3/R8: byte write sweep; read-only and unimplemented offsets ack but discard.
        for (int o = 0; o <= 21; o++) begin
            int off = (o == 21) ? 127 : o;
            logic [7:0] v = 8'((off * 29 + 7) ^ 'hA5);
            byte_write(7'(off), v, ok);
            chk(ok, "R3 byte write ack", 128'(ok), 128'(1));
            if (is_writable(off)) expv[off] = v;
        end
        sweep_reads("R3/R8");
        chk(cfg === exp_cfg(), "R10 cfg_o after writes", 128'(cfg), 128'(exp_cfg()));

        // R8: status byte follows the input.
        strap = 6'h14; expv[5] = 8'h14;
        byte_read(7'd5, d, ok);
        chk(d === 8'h14, "R8 status read", 128'(d), 128'(8'h14));

        // R5: block write count + three bytes to indices 4,5,6 (5 discarded).
        bus_start(); send_byte(8'hD2, a1); send_byte(8'h00, a2); send_byte(8'h03, a3);
        chk(a1 && a2 && a3, "R5 block header ack", 128'({a1, a2, a3}), 128'(3'b111));
        send_byte(8'h3C, a1); send_byte(8'h99, a2); send_byte(8'h6E, a3); bus_stop();
        chk(a1 && a2 && a3, "R5 block data ack", 128'({a1, a2, a3}), 128'(3'b111));
        expv[4] = 8'h3C; expv[6] = 8'h6E;
        chk(cfg === exp_cfg(), "R5 block write stored", 128'(cfg), 128'(exp_cfg()));

        // R6: block read of count plus all 11 bytes.
        bus_start(); send_byte(8'hD2, a1); send_byte(8'h00, a2);
        bus_start(); send_byte(8'hD3, a3);
        recv_byte(d, 1'b1);
        chk(d === 8'd11, "R6 block count", 128'(d), 128'(11));
        for (int i = 0; i < 11; i++) begin
            recv_byte(d, i != 10);
            chk(d === expv[4+i], "R6 block data", 128'(d), 128'(expv[4+i]));
        end
        bus_stop();

        // R1: repeated START mid-write; the second command wins.
        bus_start(); send_byte(8'hD2, a1); send_byte(8'h87, a2);
        bus_start(); send_byte(8'hD2, a3); send_byte(8'h89, a4); send_byte(8'h5A, ok); bus_stop();
        expv[9] = 8'h5A;
        chk(cfg === exp_cfg(), "R1 repeated start retargets", 128'(cfg), 128'(exp_cfg()));

        // R2: misaddressed transfer changes nothing.
        bus_start(); send_byte(8'h74, a1); send_byte(8'h86, a2); send_byte(8'h55, a3); bus_stop();
        chk(!a1 && !a2 && !a3, "R2 no ack when misaddressed", 128'({a1, a2, a3}), 128'(0));
        chk(cfg === exp_cfg(), "R2 misaddressed ignored", 128'(cfg), 128'(exp_cfg()));

        // R9: pull-down never changed while SCL high.
        chk(glitches == 0, "R9 SDA moved with SCL high", 128'(glitches), 128'(0));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule